// File: doc/BRIEF.md
# Root Lock and Barrier Arbiter

This block sits at the root of a tree-shaped synchronization network. Eight child links deliver already-decoded messages into eight one-entry input slots. A round-robin arbiter picks one occupied slot per service slot. The core acts on that message and, when the message calls for it, loads a single downward message store. The contents of that store go out to all eight children at once.

The root serializes every lock grant in the system. It keeps a table of locks, each with a held flag and the node number of its owner. A request for a held lock is dropped rather than queued. Nodes learn every grant and every release from the downward broadcast, and a node whose request was dropped tries again after it sees a release.

The root also keeps one participation mask per barrier, with one bit per child link, and records arrivals until every participating link has reported. It reflects reset and broadcast messages straight back down, and raises a sticky warning when a lock that is already free is released.

Top module: `sync_root_arbiter`

## Requirements
- R1: Each port has a one-entry slot. `in_ready[p]` is low while the slot holds a message, and a message offered while the slot is full is ignored. An accepted message is served later and is never lost.
- R2: Command 0 (reset) and command 3 (broadcast) are sent down unchanged: same command, id, node and data fields.
- R3: Command 1 creates a barrier whose participant mask is `in_mask`, with bit p standing for port p. If that barrier id is already live, the creation message is ignored and the first mask stays in force.
- R4: Command 2 (arrival) records the arriving port against a live barrier. When every port in the mask has arrived, the entry is cleared and a command 2 message goes down with that barrier id, node 0 and data 0. An arrival for a barrier that is not live produces nothing.
- R5: Command 4 (lock request) for a free lock records the requester's node field as owner. It sends down command 4 with the lock id, that node number and data 0.
- R6: Command 4 for a held lock is discarded. No downward message is sent and the owner is unchanged.
- R7: Command 5 (release) marks the lock free and sends down command 5 with the lock id, data 0 and, in the node field, the recorded owner.
- R8: Command 5 for a lock that is already free still sends command 5 down, carrying the releaser's node field. It also sets `warn_free_release`, which stays high until reset.
- R9: Occupied slots are served in round-robin order. The search starts at the port after the last one served, with port 0 first after reset, and one message is served per service slot.
- R10: There is a single downward store. While `dn_valid` is high and `dn_ready` is low, its fields stay stable and no further slot is served.
- R11: Commands 6 and 7 are discarded without any downward message.
- R12: After reset, all slots are empty (`in_ready` all ones), `dn_valid` is low, `warn_free_release` is low, all locks are free and no barrier is live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NPORT | Per-port message offer |
| in_ready | output | NPORT | Per-port slot empty |
| in_cmd | input | NPORT*3 | Per-port command code |
| in_id | input | NPORT*ID_W | Per-port barrier or lock id |
| in_node | input | NPORT*NODE_W | Per-port node number |
| in_mask | input | NPORT*NPORT | Per-port barrier participant mask |
| in_data | input | NPORT*DATA_W | Per-port payload |
| dn_valid | output | 1 | Downward store holds a message |
| dn_ready | input | 1 | Downward transmitter takes the message |
| dn_cmd | output | 3 | Downward command code |
| dn_id | output | ID_W | Downward barrier or lock id |
| dn_node | output | NODE_W | Downward node number |
| dn_data | output | DATA_W | Downward payload |
| warn_free_release | output | 1 | Sticky: a free lock was released |

## Verification
The assertions check three things on every cycle: that a port's slot refuses new data right after taking a message, that the downward store stays stable while it is stalled, and that the warning flag never falls. They also check that no reserved command and no malformed barrier completion ever appears on the downward side. Lock ownership, barrier mask bookkeeping, discarded requests and the round-robin order depend on history across many messages, so only the bench's directed scenarios show them. The bench does this by comparing the log of downward messages against the expected sequence.

// File: rtl/sync_root_pkg.sv
package sync_root_pkg;
   localparam int CMD_W = 3;

   typedef enum logic [CMD_W-1:0] {
      CMD_RESET    = 3'd0,
      CMD_BAR_NEW  = 3'd1,
      CMD_BAR_HIT  = 3'd2,
      CMD_BCAST    = 3'd3,
      CMD_LOCK_GET = 3'd4,
      CMD_LOCK_PUT = 3'd5,
      CMD_RSV6     = 3'd6,
      CMD_RSV7     = 3'd7
   } cmd_e;
endpackage

// File: rtl/sync_root_inq.sv
module sync_root_inq #(
   parameter int ID_W   = 8,
   parameter int NODE_W = 9,
   parameter int MASK_W = 8,
   parameter int DATA_W = 76
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [2:0]        wr_cmd,
   input  logic [ID_W-1:0]   wr_id,
   input  logic [NODE_W-1:0] wr_node,
   input  logic [MASK_W-1:0] wr_mask,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pop,
   output logic              occ,
   output logic [2:0]        rd_cmd,
   output logic [ID_W-1:0]   rd_id,
   output logic [NODE_W-1:0] rd_node,
   output logic [MASK_W-1:0] rd_mask,
   output logic [DATA_W-1:0] rd_data
);
   assign wr_ready = !occ;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ     <= 1'b0;
         rd_cmd  <= '0;
         rd_id   <= '0;
         rd_node <= '0;
         rd_mask <= '0;
         rd_data <= '0;
      end else if (wr_valid && !occ) begin
         occ     <= 1'b1;
         rd_cmd  <= wr_cmd;
         rd_id   <= wr_id;
         rd_node <= wr_node;
         rd_mask <= wr_mask;
         rd_data <= wr_data;
      end else if (pop) begin
         occ <= 1'b0;
      end
   end
endmodule

// File: rtl/sync_root_rr.sv
module sync_root_rr #(
   parameter int N = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          advance,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] gnt_idx,
   output logic          any
);
   logic [IW-1:0] ptr;

   always_comb begin
      gnt_idx = '0;
      any     = 1'b0;
      for (int off = N - 1; off >= 0; off--) begin
         int cand;
         cand = (int'(ptr) + off) % N;
         if (req[cand]) begin
            gnt_idx = IW'(cand);
            any     = 1'b1;
         end
      end
      gnt = any ? (N'(1) << gnt_idx) : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr <= '0;
      else if (advance && any)
         ptr <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + IW'(1);
   end
endmodule

// File: rtl/sync_root_lock_tbl.sv
module sync_root_lock_tbl #(
   parameter int NLOCK  = 256,
   parameter int NODE_W = 9,
   localparam int LID_W = $clog2(NLOCK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_get,
   input  logic              op_put,
   input  logic [LID_W-1:0]  lid,
   input  logic [NODE_W-1:0] node,
   output logic              is_free,
   output logic [NODE_W-1:0] owner
);
   logic [NLOCK-1:0]  held;
   logic [NODE_W-1:0] own_q [NLOCK];

   assign is_free = !held[lid];
   assign owner   = own_q[lid];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held <= '0;
      end else if (op_get && !held[lid]) begin
         held[lid] <= 1'b1;
      end else if (op_put) begin
         held[lid] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (op_get && !held[lid])
         own_q[lid] <= node;
   end
endmodule

// File: rtl/sync_root_bar_tbl.sv
module sync_root_bar_tbl #(
   parameter int NBAR  = 256,
   parameter int NPORT = 8,
   localparam int BID_W = $clog2(NBAR),
   localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_new,
   input  logic             op_hit,
   input  logic [BID_W-1:0] bid,
   input  logic [PW-1:0]    port,
   input  logic [NPORT-1:0] new_mask,
   output logic             done
);
   logic [NBAR-1:0]  live;
   logic [NPORT-1:0] need [NBAR];
   logic [NPORT-1:0] seen [NBAR];
   logic [NPORT-1:0] seen_nx;

   always_comb begin
      seen_nx = seen[bid] | (NPORT'(1) << port);
      done    = op_hit && live[bid] && ((seen_nx & need[bid]) == need[bid]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         live <= '0;
      else if (op_new && !live[bid])
         live[bid] <= 1'b1;
      else if (done)
         live[bid] <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (op_new && !live[bid]) begin
         need[bid] <= new_mask;
         seen[bid] <= '0;
      end else if (op_hit && live[bid]) begin
         seen[bid] <= done ? '0 : seen_nx;
      end
   end
endmodule

// File: rtl/sync_root_arbiter.sv
module sync_root_arbiter
   import sync_root_pkg::*;
#(
   parameter int NPORT  = 8,
   parameter int NLOCK  = 256,
   parameter int NBAR   = 256,
   parameter int ID_W   = 8,
   parameter int NODE_W = 9,
   parameter int DATA_W = 76
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NPORT-1:0]        in_valid,
   output logic [NPORT-1:0]        in_ready,
   input  logic [NPORT*3-1:0]      in_cmd,
   input  logic [NPORT*ID_W-1:0]   in_id,
   input  logic [NPORT*NODE_W-1:0] in_node,
   input  logic [NPORT*NPORT-1:0]  in_mask,
   input  logic [NPORT*DATA_W-1:0] in_data,
   output logic                    dn_valid,
   input  logic                    dn_ready,
   output logic [2:0]              dn_cmd,
   output logic [ID_W-1:0]         dn_id,
   output logic [NODE_W-1:0]       dn_node,
   output logic [DATA_W-1:0]       dn_data,
   output logic                    warn_free_release
);
   localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1;
   localparam int LID_W = $clog2(NLOCK);
   localparam int BID_W = $clog2(NBAR);

   if (NPORT < 2) begin : g_bad_nport
      $error("NPORT must be at least 2");
   end
   if (NLOCK < 2 || LID_W > ID_W) begin : g_bad_nlock
      $error("NLOCK must fit in the id field");
   end
   if (NBAR < 2 || BID_W > ID_W) begin : g_bad_nbar
      $error("NBAR must fit in the id field");
   end

   logic [NPORT-1:0]  q_occ;
   logic [NPORT-1:0]  pop;
   logic [2:0]        q_cmd  [NPORT];
   logic [ID_W-1:0]   q_id   [NPORT];
   logic [NODE_W-1:0] q_node [NPORT];
   logic [NPORT-1:0]  q_mask [NPORT];
   logic [DATA_W-1:0] q_data [NPORT];

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      sync_root_inq #(
         .ID_W(ID_W), .NODE_W(NODE_W), .MASK_W(NPORT), .DATA_W(DATA_W)
      ) u_inq (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_valid (in_valid[p]),
         .wr_ready (in_ready[p]),
         .wr_cmd   (in_cmd[p*3 +: 3]),
         .wr_id    (in_id[p*ID_W +: ID_W]),
         .wr_node  (in_node[p*NODE_W +: NODE_W]),
         .wr_mask  (in_mask[p*NPORT +: NPORT]),
         .wr_data  (in_data[p*DATA_W +: DATA_W]),
         .pop      (pop[p]),
         .occ      (q_occ[p]),
         .rd_cmd   (q_cmd[p]),
         .rd_id    (q_id[p]),
         .rd_node  (q_node[p]),
         .rd_mask  (q_mask[p]),
         .rd_data  (q_data[p])
      );
   end

   logic [NPORT-1:0] gnt;
   logic [PW-1:0]    gnt_idx;
   logic             any;
   logic             store_free;
   logic             svc;

   assign store_free = !dn_valid || dn_ready;
   assign svc        = any && store_free;
   assign pop        = gnt & {NPORT{svc}};

   sync_root_rr #(.N(NPORT)) u_rr (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (q_occ),
      .advance (svc),
      .gnt     (gnt),
      .gnt_idx (gnt_idx),
      .any     (any)
   );

   logic [2:0]        s_cmd;
   logic [ID_W-1:0]   s_id;
   logic [NODE_W-1:0] s_node;
   logic [NPORT-1:0]  s_mask;
   logic [DATA_W-1:0] s_data;

   assign s_cmd  = q_cmd[gnt_idx];
   assign s_id   = q_id[gnt_idx];
   assign s_node = q_node[gnt_idx];
   assign s_mask = q_mask[gnt_idx];
   assign s_data = q_data[gnt_idx];

   logic              lk_get, lk_put, lk_free;
   logic [NODE_W-1:0] lk_owner;
   logic              br_new, br_hit, br_done;

   sync_root_lock_tbl #(.NLOCK(NLOCK), .NODE_W(NODE_W)) u_locks (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_get  (lk_get),
      .op_put  (lk_put),
      .lid     (s_id[LID_W-1:0]),
      .node    (s_node),
      .is_free (lk_free),
      .owner   (lk_owner)
   );

   sync_root_bar_tbl #(.NBAR(NBAR), .NPORT(NPORT)) u_bars (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_new   (br_new),
      .op_hit   (br_hit),
      .bid      (s_id[BID_W-1:0]),
      .port     (gnt_idx),
      .new_mask (s_mask),
      .done     (br_done)
   );

   logic              emit;
   logic              warn_set;
   logic [NODE_W-1:0] o_node;
   logic [DATA_W-1:0] o_data;

   always_comb begin
      lk_get   = 1'b0;
      lk_put   = 1'b0;
      br_new   = 1'b0;
      br_hit   = 1'b0;
      emit     = 1'b0;
      warn_set = 1'b0;
      o_node   = '0;
      o_data   = '0;
      if (svc) begin
         unique case (cmd_e'(s_cmd))
            CMD_RESET, CMD_BCAST: begin
               emit   = 1'b1;
               o_node = s_node;
               o_data = s_data;
            end
            CMD_BAR_NEW: br_new = 1'b1;
            CMD_BAR_HIT: begin
               br_hit = 1'b1;
               emit   = br_done;
            end
            CMD_LOCK_GET: begin
               lk_get = 1'b1;
               emit   = lk_free;
               o_node = s_node;
            end
            CMD_LOCK_PUT: begin
               lk_put   = 1'b1;
               emit     = 1'b1;
               warn_set = lk_free;
               o_node   = lk_free ? s_node : lk_owner;
            end
            default: emit = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dn_valid <= 1'b0;
         dn_cmd   <= '0;
         dn_id    <= '0;
         dn_node  <= '0;
         dn_data  <= '0;
      end else if (svc && emit) begin
         dn_valid <= 1'b1;
         dn_cmd   <= s_cmd;
         dn_id    <= s_id;
         dn_node  <= o_node;
         dn_data  <= o_data;
      end else if (dn_ready) begin
         dn_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         warn_free_release <= 1'b0;
      else if (warn_set)
         warn_free_release <= 1'b1;
   end
endmodule

// File: rtl/sync_root_checker.sv
module sync_root_checker #(
   parameter int NPORT  = 8,
   parameter int ID_W   = 8,
   parameter int NODE_W = 9,
   parameter int DATA_W = 76
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NPORT-1:0]  in_valid,
   input logic [NPORT-1:0]  in_ready,
   input logic              dn_valid,
   input logic              dn_ready,
   input logic [2:0]        dn_cmd,
   input logic [ID_W-1:0]   dn_id,
   input logic [NODE_W-1:0] dn_node,
   input logic [DATA_W-1:0] dn_data,
   input logic              warn_free_release
);
   for (genvar p = 0; p < NPORT; p++) begin : g_slot
      AST_SLOT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid[p] && in_ready[p] |=> !in_ready[p]); // R1
   end

   AST_STORE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && !dn_ready |=> dn_valid && $stable(dn_cmd) && $stable(dn_id)
                                 && $stable(dn_node) && $stable(dn_data)); // R10

   AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      warn_free_release |=> warn_free_release); // R8

   AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dn_valid) |-> $past(in_ready) != {NPORT{1'b1}}); // R9

   AST_NO_RESERVED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> dn_cmd != 3'd1 && dn_cmd != 3'd6 && dn_cmd != 3'd7); // R11

   AST_BAR_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && dn_cmd == 3'd2 |-> dn_node == '0 && dn_data == '0); // R4
endmodule

bind sync_root_arbiter sync_root_checker #(
   .NPORT(NPORT), .ID_W(ID_W), .NODE_W(NODE_W), .DATA_W(DATA_W)
) u_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .in_valid          (in_valid),
   .in_ready          (in_ready),
   .dn_valid          (dn_valid),
   .dn_ready          (dn_ready),
   .dn_cmd            (dn_cmd),
   .dn_id             (dn_id),
   .dn_node           (dn_node),
   .dn_data           (dn_data),
   .warn_free_release (warn_free_release)
);

// File: tb/sync_root_arbiter_bench.sv
`timescale 1ns/100ps
module sync_root_arbiter_bench;
   localparam int NPORT = 8, ID_W = 8, NODE_W = 9, DATA_W = 76;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NPORT-1:0]        in_valid = '0;
   logic [NPORT-1:0]        in_ready;
   logic [NPORT*3-1:0]      in_cmd = '0;
   logic [NPORT*ID_W-1:0]   in_id = '0;
   logic [NPORT*NODE_W-1:0] in_node = '0;
   logic [NPORT*NPORT-1:0]  in_mask = '0;
   logic [NPORT*DATA_W-1:0] in_data = '0;
   logic                    dn_valid;
   logic                    dn_ready = 1'b1;
   logic [2:0]              dn_cmd;
   logic [ID_W-1:0]         dn_id;
   logic [NODE_W-1:0]       dn_node;
   logic [DATA_W-1:0]       dn_data;
   logic                    warn_free_release;

   always #2 clk = ~clk;

   sync_root_arbiter u_sync_root_arbiter (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_cmd(in_cmd), .in_id(in_id), .in_node(in_node), .in_mask(in_mask),
      .in_data(in_data), .dn_valid(dn_valid), .dn_ready(dn_ready),
      .dn_cmd(dn_cmd), .dn_id(dn_id), .dn_node(dn_node), .dn_data(dn_data),
      .warn_free_release(warn_free_release)
   );

   int n_chk = 0;
   int n_err = 0;
   int mon_n = 0;
   logic [95:0] mon_log [64];

   // Log every message the transmitter takes, sampled mid-cycle
   always begin
      @(negedge clk);
      #1.5;
      if (rst_n && dn_valid && dn_ready && mon_n < 64) begin
         mon_log[mon_n] = {dn_cmd, dn_id, dn_node, dn_data};
         mon_n++;
      end
   end

   initial begin
      #400000;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic put(input int p, input logic [2:0] c, input logic [ID_W-1:0] id,
                      input logic [NODE_W-1:0] nd, input logic [NPORT-1:0] m,
                      input logic [DATA_W-1:0] d);
      in_valid[p] = 1'b1;
      in_cmd[p*3 +: 3] = c;
      in_id[p*ID_W +: ID_W] = id;
      in_node[p*NODE_W +: NODE_W] = nd;
      in_mask[p*NPORT +: NPORT] = m;
      in_data[p*DATA_W +: DATA_W] = d;
   endtask

   task automatic fire();
      tick(1);
      in_valid = '0;
   endtask

   task automatic expect_msg(input int idx, input string req, input logic [2:0] c,
                             input logic [ID_W-1:0] id, input logic [NODE_W-1:0] nd,
                             input logic [DATA_W-1:0] d);
      logic [95:0] e;
      e = {c, id, nd, d};
      if (idx >= mon_n) chk(1'b0, req, 128'(mon_n), 128'(idx + 1));
      else chk(mon_log[idx] == e, req, 128'(mon_log[idx]), 128'(e));
   endtask

   task automatic expect_none(input int n0, input string req);
      chk(mon_n == n0, req, 128'(mon_n), 128'(n0));
   endtask

   task automatic t_reset();
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk(in_ready == '1, "R12 slots empty", 128'(in_ready), 128'hFF);
      chk(dn_valid == 1'b0, "R12 store empty", 128'(dn_valid), 0);
      chk(warn_free_release == 1'b0, "R12 warn low", 128'(warn_free_release), 0);
   endtask

   task automatic t_round_robin();
      int n0;
      n0 = mon_n;
      put(5, 3'd3, 8'd5, 9'd0, '0, 76'h5);
      put(2, 3'd3, 8'd2, 9'd0, '0, 76'h2);
      put(7, 3'd3, 8'd7, 9'd0, '0, 76'h7);
      fire();
      tick(10);
      expect_msg(n0,     "R9 first", 3'd3, 8'd2, 9'd0, 76'h2);
      expect_msg(n0 + 1, "R9 second", 3'd3, 8'd5, 9'd0, 76'h5);
      expect_msg(n0 + 2, "R9 third", 3'd3, 8'd7, 9'd0, 76'h7);
      n0 = mon_n;
      put(1, 3'd3, 8'd1, 9'd0, '0, 76'h1);
      put(6, 3'd3, 8'd6, 9'd0, '0, 76'h6);
      put(3, 3'd3, 8'd3, 9'd0, '0, 76'h3);
      fire();
      tick(10);
      expect_msg(n0,     "R9 wrap first", 3'd3, 8'd1, 9'd0, 76'h1);
      expect_msg(n0 + 1, "R9 wrap second", 3'd3, 8'd3, 9'd0, 76'h3);
      expect_msg(n0 + 2, "R9 wrap third", 3'd3, 8'd6, 9'd0, 76'h6);
      n0 = mon_n;
      put(0, 3'd3, 8'd0, 9'd0, '0, 76'h10);
      put(7, 3'd3, 8'd7, 9'd0, '0, 76'h17);
      fire();
      tick(10);
      expect_msg(n0,     "R9 pointer at 7", 3'd3, 8'd7, 9'd0, 76'h17);
      expect_msg(n0 + 1, "R9 then 0", 3'd3, 8'd0, 9'd0, 76'h10);
   endtask

   task automatic t_hold();
      int n0;
      n0 = mon_n;
      dn_ready = 1'b0;
      put(1, 3'd3, 8'h11, 9'd0, '0, 76'hA);
      put(2, 3'd3, 8'h22, 9'd0, '0, 76'hB);
      fire();
      tick(6);
      chk(dn_valid == 1'b1 && dn_data == 76'hA, "R10 store held", 128'(dn_data), 128'hA);
      chk(in_ready[2] == 1'b0, "R1 slot stays full", 128'(in_ready[2]), 0);
      put(2, 3'd3, 8'h33, 9'd0, '0, 76'hC);
      fire();
      tick(4);
      chk(dn_data == 76'hA && dn_id == 8'h11, "R10 still stable", 128'(dn_data), 128'hA);
      dn_ready = 1'b1;
      tick(8);
      expect_msg(n0,     "R10 first out", 3'd3, 8'h11, 9'd0, 76'hA);
      expect_msg(n0 + 1, "R1 queued message kept", 3'd3, 8'h22, 9'd0, 76'hB);
      expect_none(n0 + 2, "R1 offer to full slot ignored");
   endtask

   task automatic t_reflect();
      int n0;
      n0 = mon_n;
      put(6, 3'd0, 8'h3C, 9'h155, '0, 76'hABC_DEF0_1234_5678_9AB);
      fire();
      tick(6);
      expect_msg(n0, "R2 reset reflected", 3'd0, 8'h3C, 9'h155, 76'hABC_DEF0_1234_5678_9AB);
      put(4, 3'd3, 8'hFF, 9'h1FF, '0, {76{1'b1}});
      fire();
      tick(6);
      expect_msg(n0 + 1, "R2 broadcast reflected", 3'd3, 8'hFF, 9'h1FF, {76{1'b1}});
   endtask

   task automatic t_reserved();
      int n0;
      n0 = mon_n;
      put(3, 3'd6, 8'd1, 9'd1, '0, 76'h1);
      put(4, 3'd7, 8'd2, 9'd2, '0, 76'h2);
      fire();
      tick(8);
      expect_none(n0, "R11 reserved commands dropped");
      chk(in_ready == '1, "R11 slots drained", 128'(in_ready), 128'hFF);
   endtask

   task automatic t_barrier();
      int n0;
      n0 = mon_n;
      put(0, 3'd1, 8'd3, 9'd0, 8'h05, '0);
      put(2, 3'd1, 8'd3, 9'd0, 8'hFF, '0);
      fire();
      tick(6);
      expect_none(n0, "R3 creation sends nothing");
      put(0, 3'd2, 8'd3, 9'd0, '0, '0);
      put(1, 3'd2, 8'd3, 9'd0, '0, '0);
      fire();
      tick(6);
      expect_none(n0, "R4 partial arrivals");
      put(2, 3'd2, 8'd3, 9'd0, '0, '0);
      fire();
      tick(6);
      expect_msg(n0, "R3 first mask kept, R4 done", 3'd2, 8'd3, 9'd0, 76'd0);
      put(0, 3'd2, 8'd3, 9'd0, '0, '0);
      put(2, 3'd2, 8'd3, 9'd0, '0, '0);
      fire();
      tick(6);
      expect_none(n0 + 1, "R4 cleared entry ignores arrivals");
      put(1, 3'd1, 8'd4, 9'd0, 8'h06, '0);
      fire();
      tick(4);
      put(5, 3'd2, 8'd4, 9'd0, '0, '0);
      put(1, 3'd2, 8'd4, 9'd0, '0, '0);
      fire();
      tick(6);
      expect_none(n0 + 1, "R4 outside port does not complete");
      put(2, 3'd2, 8'd4, 9'd0, '0, '0);
      fire();
      tick(6);
      expect_msg(n0 + 1, "R4 second barrier done", 3'd2, 8'd4, 9'd0, 76'd0);
   endtask

   task automatic t_locks();
      int n0;
      n0 = mon_n;
      put(3, 3'd4, 8'd7, 9'h1A5, '0, 76'h99);
      fire();
      tick(6);
      expect_msg(n0, "R5 grant", 3'd4, 8'd7, 9'h1A5, 76'd0);
      put(4, 3'd4, 8'd7, 9'h011, '0, '0);
      fire();
      tick(6);
      expect_none(n0 + 1, "R6 held lock request dropped");
      put(3, 3'd5, 8'd7, 9'h1A5, '0, '0);
      fire();
      tick(6);
      expect_msg(n0 + 1, "R7 release", 3'd5, 8'd7, 9'h1A5, 76'd0);
      chk(warn_free_release == 1'b0, "R8 no warn on held release", 128'(warn_free_release), 0);
      put(4, 3'd4, 8'd7, 9'h011, '0, '0);
      fire();
      tick(6);
      expect_msg(n0 + 2, "R7 retry granted", 3'd4, 8'd7, 9'h011, 76'd0);
      put(2, 3'd5, 8'd7, 9'h0F0, '0, '0);
      fire();
      tick(6);
      expect_msg(n0 + 3, "R7 release carries owner", 3'd5, 8'd7, 9'h011, 76'd0);
      put(5, 3'd5, 8'd9, 9'h033, '0, '0);
      fire();
      tick(6);
      expect_msg(n0 + 4, "R8 free release broadcast", 3'd5, 8'd9, 9'h033, 76'd0);
      chk(warn_free_release == 1'b1, "R8 warn set", 128'(warn_free_release), 1);
      put(0, 3'd4, 8'hFF, 9'h1FF, '0, '0);
      fire();
      tick(6);
      expect_msg(n0 + 5, "R5 top lock grant", 3'd4, 8'hFF, 9'h1FF, 76'd0);
      put(1, 3'd4, 8'hFF, 9'h002, '0, '0);
      fire();
      tick(6);
      expect_none(n0 + 6, "R6 top lock denied");
      chk(warn_free_release == 1'b1, "R8 warn sticky", 128'(warn_free_release), 1);
   endtask

   initial begin
      t_reset();
      t_round_robin();
      t_hold();
      t_reflect();
      t_reserved();
      t_barrier();
      t_locks();
      tick(4);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule